// File: doc/BRIEF.md
# External Interrupt Request Latch

This block sits between eight external interrupt pins and a downstream priority resolver. Every pin is first brought into the clock domain by a two-flop synchronizer. Each pin then works in one of two ways. It can be an individual request line, sensed on a chosen edge or on a high level. It can also be one bit of a 4-bit encoded level that its group of four pins carries. Pins 3:0 form group 0 and pins 7:4 form group 1.

The block holds each detected request until software removes it. The way to remove a request depends on how it was detected:
- An edge request is cleared by reading its status bit as 1 and then writing 0 to that bit.
- A held level request is cleared by writing 1 to its mask-set bit.
- A held group code is cleared by writing 1 to its group clear bit.

A live-mode control bit turns off holding for level lines and groups, so their outputs follow the synchronized pins. Edge requests are still held in live mode. Masks hide pending requests from the outputs without erasing them.

Software reaches the block through a small register bus. Writes take effect at the clock edge where `bus_wr` is high. Reads are combinational on `bus_rdata`. A read strobe on the status address arms the clear of edge requests.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, `line_pend`, `grp_pend`, `grp_level` and `line_prio` are 0, and every register reads 0. Register addresses: 0 status, 1 mask-set, 2 mask-clear, 3 sense, 4 polarity, 5 control, 6 group clear, 7 group unmask, 8 level mask low, 9 level mask high, 10 priority low, 11 priority high.
- R2: A line whose sense bit (address 3) is 1 latches a request on a rising edge of its pin when its polarity bit (address 4) is 1, and on a falling edge when that bit is 0. The opposite edge does nothing, and the request stays pending after the pin returns.
- R3: An edge request is cleared only by writing 0 to its status bit after a read of address 0 has returned that bit as 1. Writing 0 without such a read leaves it pending, and writing 1 has no effect.
- R4: `line_pend` is the line's held state ANDed with the inverse of its mask bit. Writing 1 to address 1 sets mask bits and writing 1 to address 2 clears them; both addresses read the mask. Setting the mask of an edge line does not clear its request.
- R5: With live mode off, a line whose sense bit is 0 latches a high synchronized level and holds it after the pin falls. Writing 1 to its bit at address 1 clears the held request.
- R6: Each line has a 2-bit priority field, lines 3:0 at address 10 and lines 7:4 at address 11, two bits per line in line order. The fields drive `line_prio`. Writing priority 0 does not clear a pending request.
- R7: Address 0 returns the held request of each individual line, and the live level of level lines in live mode, regardless of the mask.
- R8: Control bit 1 (group 0) and control bit 2 (group 1) at address 5 put a group's pins in encoded mode, and those lines then give no `line_pend`. A nonzero code is held and shown on `grp_pend` and `grp_level`. Writing 1 to a group's bit at address 6 clears the held code and masks the group. Writing 1 at address 7 unmasks the group.
- R9: Level mask bit k, at address 8 for codes 7..0 and at address 9 for codes 15..8, hides a group request with code k without clearing it.
- R10: With control bit 0 (live mode) set, level lines and encoded groups hold nothing and follow the synchronized pins, while edge lines still hold their requests.
- R11: If a new selected edge arrives in the same cycle as a valid edge clear, the request stays pending, and a further clear needs a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | External interrupt pins, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms edge clears) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| line_pend | output | 8 | Unmasked pending individual requests |
| line_prio | output | 16 | Per-line priority fields |
| grp_pend | output | 2 | Pending encoded-level group requests |
| grp_level | output | 8 | Code of each pending group, 0 when not pending |

## Verification
A held bit that is lost or stuck shows on `line_pend` or `grp_pend` three clocks after a pin change. It also shows at once on the status read. The bench therefore probes each mode after the pin has returned to idle, where only the held state can keep the output high. Arming faults appear as a clear that succeeds without a read, or that fails after one, in the first cycle after the write. The edge-versus-clear collision is staged on the exact cycle in which the synchronized edge and the write meet.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   typedef enum logic [3:0] {
      A_STAT    = 4'd0,
      A_MSET    = 4'd1,
      A_MCLR    = 4'd2,
      A_SENSE   = 4'd3,
      A_POL     = 4'd4,
      A_CTRL    = 4'd5,
      A_GCLR    = 4'd6,
      A_GUNM    = 4'd7,
      A_LVL_LO  = 4'd8,
      A_LVL_HI  = 4'd9,
      A_PRI_LO  = 4'd10,
      A_PRI_HI  = 4'd11
   } reg_addr_e;
endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         q      <= '0;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/eil_line.sv
module eil_line (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic sense_edge,
   input  logic rise,
   input  logic live_mode,
   input  logic grp_owned,
   input  logic stat_rd,
   input  logic stat_wr,
   input  logic stat_wbit,
   input  logic mask_set_wr,
   input  logic mask_bit,
   output logic raw,
   output logic pend
);
   logic prev, held, armed, held_n, armed_n;
   logic edge_ev, clr_edge;

   assign edge_ev  = !grp_owned && sense_edge &&
                     (rise ? (smp && !prev) : (!smp && prev));
   assign clr_edge = stat_wr && !stat_wbit && armed;

   always_comb begin
      if (grp_owned)
         held_n = 1'b0;
      else if (sense_edge)
         held_n = edge_ev || (held && !clr_edge);
      else if (live_mode)
         held_n = 1'b0;
      else
         held_n = smp || (held && !mask_set_wr);
   end

   always_comb begin
      if (grp_owned || !sense_edge || clr_edge)
         armed_n = 1'b0;
      else if (stat_rd && held)
         armed_n = 1'b1;
      else
         armed_n = armed;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         held  <= 1'b0;
         armed <= 1'b0;
      end else begin
         prev  <= smp;
         held  <= held_n;
         armed <= armed_n;
      end
   end

   assign raw  = grp_owned ? 1'b0 : ((!sense_edge && live_mode) ? smp : held);
   assign pend = raw && !mask_bit;

   // R3
   edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_edge && !grp_owned && held && !armed) |=> held);

   // R5
   level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_edge && !grp_owned && !live_mode && held && !mask_set_wr) |=> held);

   // R11
   edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_ev |=> held);
endmodule

// File: rtl/eil_group.sv
module eil_group #(
   parameter int GROUP_W = 4,
   localparam int LVL_N = 1 << GROUP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [GROUP_W-1:0] code,
   input  logic               en,
   input  logic               live_mode,
   input  logic               clr,
   input  logic               gmask,
   input  logic [LVL_N-1:0]   lvlmask,
   output logic               req,
   output logic [GROUP_W-1:0] level
);
   logic [GROUP_W-1:0] held, held_n, eff;

   always_comb begin
      if (!en || live_mode)
         held_n = '0;
      else if (|code)
         held_n = code;
      else if (clr)
         held_n = '0;
      else
         held_n = held;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else        held <= held_n;
   end

   assign eff   = live_mode ? code : held;
   assign req   = en && (|eff) && !gmask && !lvlmask[eff];
   assign level = req ? eff : '0;

   // R8
   grp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !live_mode && (held != '0) && !clr) |=> (held != '0));

   // R10
   grp_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_mode || !en) |=> (held == '0));
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int GROUP_W   = 4,
   parameter int PRIO_W    = 2,
   localparam int NUM_GRP  = NUM_LINES / GROUP_W,
   localparam int PRIO_BITS = NUM_LINES * PRIO_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LINES-1:0]         irq_pin,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   input  logic [3:0]                   bus_addr,
   input  logic [NUM_LINES-1:0]         bus_wdata,
   output logic [NUM_LINES-1:0]         bus_rdata,
   output logic [NUM_LINES-1:0]         line_pend,
   output logic [PRIO_BITS-1:0]         line_prio,
   output logic [NUM_GRP-1:0]           grp_pend,
   output logic [NUM_GRP*GROUP_W-1:0]   grp_level
);
   localparam int LVL_N = 1 << GROUP_W;

   if (NUM_LINES % GROUP_W != 0) begin : g_bad_split
      $error("NUM_LINES must be a multiple of GROUP_W");
   end
   if (LVL_N > 2 * NUM_LINES) begin : g_bad_lvl
      $error("level mask does not fit two registers");
   end
   if (PRIO_BITS > 2 * NUM_LINES) begin : g_bad_prio
      $error("priority fields do not fit two registers");
   end
   if (NUM_GRP + 1 > NUM_LINES) begin : g_bad_ctrl
      $error("control bits exceed data width");
   end

   logic [NUM_LINES-1:0] pin_s, mask_q, sense_q, pol_q, line_raw;
   logic [NUM_LINES-1:0] lvl_lo_q, lvl_hi_q, pri_lo_q, pri_hi_q;
   logic [NUM_GRP:0]     ctrl_q;
   logic [NUM_GRP-1:0]   gmask_q;
   logic [LVL_N-1:0]     lvlmask;
   logic [2*NUM_LINES-1:0] lvl_full, pri_full;

   eil_sync #(.W(NUM_LINES)) u_sync (.clk(clk), .rst_n(rst_n), .d(irq_pin), .q(pin_s));

   function automatic logic wr_at(input reg_addr_e a);
      return bus_wr && (bus_addr == a);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         sense_q  <= '0;
         pol_q    <= '0;
         ctrl_q   <= '0;
         gmask_q  <= '0;
         lvl_lo_q <= '0;
         lvl_hi_q <= '0;
         pri_lo_q <= '0;
         pri_hi_q <= '0;
      end else begin
         if (wr_at(A_MSET))   mask_q   <= mask_q | bus_wdata;
         if (wr_at(A_MCLR))   mask_q   <= mask_q & ~bus_wdata;
         if (wr_at(A_SENSE))  sense_q  <= bus_wdata;
         if (wr_at(A_POL))    pol_q    <= bus_wdata;
         if (wr_at(A_CTRL))   ctrl_q   <= bus_wdata[NUM_GRP:0];
         if (wr_at(A_GCLR))   gmask_q  <= gmask_q | bus_wdata[NUM_GRP-1:0];
         if (wr_at(A_GUNM))   gmask_q  <= gmask_q & ~bus_wdata[NUM_GRP-1:0];
         if (wr_at(A_LVL_LO)) lvl_lo_q <= bus_wdata;
         if (wr_at(A_LVL_HI)) lvl_hi_q <= bus_wdata;
         if (wr_at(A_PRI_LO)) pri_lo_q <= bus_wdata;
         if (wr_at(A_PRI_HI)) pri_hi_q <= bus_wdata;
      end
   end

   assign lvl_full  = {lvl_hi_q, lvl_lo_q};
   assign pri_full  = {pri_hi_q, pri_lo_q};
   assign lvlmask   = lvl_full[LVL_N-1:0];
   assign line_prio = pri_full[PRIO_BITS-1:0];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      eil_line u_line (
         .clk(clk), .rst_n(rst_n), .smp(pin_s[i]),
         .sense_edge(sense_q[i]), .rise(pol_q[i]), .live_mode(ctrl_q[0]),
         .grp_owned(ctrl_q[1 + i / GROUP_W]),
         .stat_rd(bus_rd && (bus_addr == A_STAT)),
         .stat_wr(wr_at(A_STAT)), .stat_wbit(bus_wdata[i]),
         .mask_set_wr(wr_at(A_MSET) && bus_wdata[i]),
         .mask_bit(mask_q[i]), .raw(line_raw[i]), .pend(line_pend[i]));
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      eil_group #(.GROUP_W(GROUP_W)) u_grp (
         .clk(clk), .rst_n(rst_n),
         .code(pin_s[g*GROUP_W +: GROUP_W]),
         .en(ctrl_q[1 + g]), .live_mode(ctrl_q[0]),
         .clr(wr_at(A_GCLR) && bus_wdata[g]),
         .gmask(gmask_q[g]), .lvlmask(lvlmask),
         .req(grp_pend[g]), .level(grp_level[g*GROUP_W +: GROUP_W]));
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_STAT:           bus_rdata = line_raw;
         A_MSET, A_MCLR:   bus_rdata = mask_q;
         A_SENSE:          bus_rdata = sense_q;
         A_POL:            bus_rdata = pol_q;
         A_CTRL:           bus_rdata[NUM_GRP:0] = ctrl_q;
         A_GCLR, A_GUNM:   bus_rdata[NUM_GRP-1:0] = gmask_q;
         A_LVL_LO:         bus_rdata = lvl_lo_q;
         A_LVL_HI:         bus_rdata = lvl_hi_q;
         A_PRI_LO:         bus_rdata = pri_lo_q;
         A_PRI_HI:         bus_rdata = pri_hi_q;
         default:          bus_rdata = '0;
      endcase
   end

   // R4
   mask_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pend & mask_q) == '0);

   // R8
   gmask_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_pend & gmask_q) == '0);
endmodule

// File: tb/ext_irq_latch_tb.sv
`timescale 1ns/1ps
module ext_irq_latch_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_pin = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata, line_pend, grp_level;
   logic [15:0] line_prio;
   logic [1:0]  grp_pend;
   int checks = 0, errors = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   ext_irq_latch u_dut (
      .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .line_pend(line_pend), .line_prio(line_prio), .grp_pend(grp_pend),
      .grp_level(grp_level));

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_pin = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      chk("R1 line_pend", line_pend, 0);
      chk("R1 grp_pend/level", {grp_pend, grp_level}, 0);
      chk("R1 line_prio", line_prio, 0);
      for (int a = 0; a < 12; a++) begin
         rd(4'(a), d);
         chk($sformatf("R1 reg %0d", a), d, 0);
      end
   endtask

   task automatic t_edge();
      logic [7:0] d;
      do_reset();
      wr(3, 8'h03); wr(4, 8'h01);
      irq_pin = 8'h02; settle();
      chk("R2 wrong edge ignored", line_pend, 8'h00);
      irq_pin = 8'h01; settle();
      chk("R2 rise and fall latched", line_pend, 8'h03);
      irq_pin = 8'h00; settle();
      chk("R2 held after pin idle", line_pend, 8'h03);
      wr(0, 8'h00);
      chk("R3 clear without read", line_pend, 8'h03);
      rd(0, d);
      chk("R3 status read", d, 8'h03);
      wr(0, 8'h02);
      chk("R3 write 0 clears only bit0", line_pend, 8'h02);
      wr(0, 8'h00);
      chk("R3 armed bit1 clears", line_pend, 8'h00);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      do_reset();
      wr(3, 8'h01); wr(4, 8'h01);
      irq_pin = 8'h01; settle(); irq_pin = 8'h00; settle();
      wr(1, 8'h01);
      chk("R4 mask hides", line_pend, 8'h00);
      rd(0, d);
      chk("R4 mask keeps edge", d, 8'h01);
      rd(2, d);
      chk("R4 mask readback", d, 8'h01);
      wr(2, 8'h01);
      chk("R4 unmask shows again", line_pend, 8'h01);
   endtask

   task automatic t_level();
      logic [7:0] d;
      do_reset();
      irq_pin = 8'h10; settle();
      chk("R5 level latched", line_pend, 8'h10);
      irq_pin = 8'h00; settle();
      chk("R5 level held", line_pend, 8'h10);
      rd(0, d);
      chk("R7 status shows level", d, 8'h10);
      wr(11, 8'h00);
      chk("R6 priority 0 keeps request", line_pend, 8'h10);
      wr(11, 8'hAB); wr(10, 8'h1E);
      chk("R6 priority out", line_prio, 16'hAB1E);
      wr(0, 8'h00);
      chk("R5 status write ignored", line_pend, 8'h10);
      wr(1, 8'h10);
      rd(0, d);
      chk("R5 mask-set clears", d, 8'h00);
      wr(2, 8'h10);
      chk("R5 stays clear after unmask", line_pend, 8'h00);
   endtask

   task automatic t_live();
      logic [7:0] d;
      do_reset();
      wr(5, 8'h01); wr(3, 8'h01); wr(4, 8'h01);
      irq_pin = 8'h05; settle();
      chk("R10 live follows", line_pend, 8'h05);
      rd(0, d);
      chk("R7 live status", d, 8'h05);
      irq_pin = 8'h00; settle();
      chk("R10 level not held, edge held", line_pend, 8'h01);
   endtask

   task automatic t_group();
      do_reset();
      wr(5, 8'h02);
      irq_pin = 8'h05; settle();
      chk("R8 group code", {6'd0, grp_pend, grp_level}, 16'h0105);
      chk("R8 owned lines silent", line_pend, 8'h00);
      irq_pin = 8'h00; settle();
      chk("R8 group held", {6'd0, grp_pend, grp_level}, 16'h0105);
      wr(8, 8'h20);
      chk("R9 level mask hides", {6'd0, grp_pend, grp_level}, 16'h0000);
      wr(8, 8'h00);
      chk("R9 level mask kept", {6'd0, grp_pend, grp_level}, 16'h0105);
      wr(6, 8'h01); wr(7, 8'h01);
      chk("R8 group clear", {6'd0, grp_pend, grp_level}, 16'h0000);
      wr(5, 8'h03);
      irq_pin = 8'h03; settle();
      chk("R10 group live", {6'd0, grp_pend, grp_level}, 16'h0103);
      irq_pin = 8'h00; settle();
      chk("R10 group not held", {6'd0, grp_pend}, 0);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      do_reset();
      wr(3, 8'h01); wr(4, 8'h01);
      irq_pin = 8'h01; settle();
      rd(0, d);
      irq_pin = 8'h00; settle();
      chk("R11 pending before", line_pend, 8'h01);
      irq_pin = 8'h01;
      repeat (2) @(negedge clk);
      wr(0, 8'h00);
      chk("R11 edge beats clear", line_pend, 8'h01);
      wr(0, 8'h00);
      chk("R11 needs new read", line_pend, 8'h01);
      rd(0, d); wr(0, 8'h00);
      chk("R11 clear after read", line_pend, 8'h00);
   endtask

   initial begin
      t_reset();
      t_edge();
      t_mask();
      t_level();
      t_live();
      t_group();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule